// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Buffer Steering

This block sits after the stage that assembles a complete CAN frame. When that stage presents a frame with a one-cycle valid strobe, the block matches it against six programmable acceptance filters under two masks. It decides whether the frame is kept and which of two receive buffers takes it. It also reports which filter caused the acceptance. If the chosen buffer still holds an unread frame, the block flags an overflow and drops the new frame. An optional rollover lets a frame meant for the first buffer spill into the second when the first is occupied.

Buffer 0 is the higher-priority buffer. Its mask pairs with the first two filters. Buffer 1 has its own mask and the remaining four filters. For standard data frames, the low sixteen mask and filter bits, which extended identifiers would otherwise use, are compared against the first two data bytes. Each buffer has a mode field, and one of its settings disables filtering for that buffer. Filters and masks are written through a small configuration port. That port works only while configuration mode is held, and it reads zero at all other times.

Top module: `can_accept_steer`

## Requirements
- R1: Eight 30-bit registers (bit 29 = extended-identifier enable, bits 28:0 = identifier bits) are selected by a 3-bit index: 0 = mask 0, 1 = mask 1, 2..7 = filters 0..5. A write takes effect only when cfg_mode is high. A write attempted while cfg_mode is low leaves the register unchanged.
- R2: While cfg_mode is low, the readback port returns all zeros. While cfg_mode is high, it returns the selected register combinationally.
- R3: A mask bit of 1 requires the frame bit to equal the filter bit. A mask bit of 0 excludes that bit from the comparison.
- R4: A filter can hit only if its extended-identifier enable bit equals the frame's IDE flag. Extended frames compare all 29 identifier bits. Standard frames carry their 11-bit identifier in frm_id[28:18] and compare only those bits.
- R5: Buffer 0 uses mask 0 with filters 0 and 1. Buffer 1 uses mask 1 with filters 2 to 5. Within a buffer the lowest-numbered hitting filter is reported on hit_idx, which changes only when a frame is loaded.
- R6: For a standard data frame (IDE=0, RTR=0), frm_data[15:8] (byte 0) and frm_data[7:0] (byte 1) are also compared against mask/filter bits 15:0. Standard remote frames skip this data comparison.
- R7: A frame accepted by both buffers goes to buffer 0.
- R8: If rollover_en is high, buf_full[0] is high and the frame is accepted for buffer 0, the frame is loaded into buffer 1 instead, with buffer 0's hit index.
- R9: A buffer mode value of 2'b11 disables filtering for that buffer, so it accepts every frame. Such an acceptance reports hit_idx = 7.
- R10: If the target buffer's full flag is high, no load strobe occurs, the frame is dropped and overflow pulses.
- R11: load0, load1 and overflow are single-cycle pulses in the cycle after frm_valid. At most one of them is high, and none is high without a preceding frm_valid.
- R12: irq_req is high in the cycle after any load, and in every cycle that follows a clock edge at which any buf_full bit was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode; enables register writes and readback |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register index to write |
| cfg_wr_ide | input | 1 | Extended-identifier enable bit to write |
| cfg_wr_bits | input | 29 | Identifier bits to write |
| cfg_rd_sel | input | 3 | Register index to read |
| cfg_rd_ide | output | 1 | Readback extended-identifier enable bit |
| cfg_rd_bits | output | 29 | Readback identifier bits |
| buf0_mode | input | 2 | Buffer 0 mode (2'b11 = accept all) |
| buf1_mode | input | 2 | Buffer 1 mode (2'b11 = accept all) |
| rollover_en | input | 1 | Enables spill from buffer 0 to buffer 1 |
| frm_valid | input | 1 | One-cycle strobe: a complete frame is present |
| frm_ide | input | 1 | Frame uses a 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Frame identifier (standard: bits 28:18) |
| frm_data | input | 16 | Data byte 0 in 15:8, byte 1 in 7:0 |
| buf_full | input | 2 | Per-buffer unread flag |
| load0 | output | 1 | Load strobe for buffer 0 |
| load1 | output | 1 | Load strobe for buffer 1 |
| hit_idx | output | 3 | Index of the accepting filter (7 = filtering off) |
| overflow | output | 1 | Frame dropped because its target was full |
| irq_req | output | 1 | Buffer-full interrupt request |

## Verification
A corrupted mask or filter register shows up at the next frame that exercises its bits: the frame goes to the wrong buffer, is dropped, or reports a different hit_idx, one cycle after frm_valid. A bad priority or rollover decision shows up the same way, on the pair of load strobes or the overflow pulse. Configuration state is also observed directly through the readback port. There, a write that slipped through outside configuration mode becomes visible as soon as configuration mode is re-entered.

// File: rtl/can_accept_pkg.sv
package can_accept_pkg;
  localparam int ID_W     = 29;
  localparam int SID_W    = 11;
  localparam int DB_W     = 16;
  localparam int NUM_FILT = 6;
  localparam int NUM_B0   = 2;
  localparam int NUM_REG  = NUM_FILT + 2;
  localparam int SEL_W    = $clog2(NUM_REG);
  localparam int IDX_W    = 3;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;
  localparam logic [1:0] MODE_ALL = 2'b11;

  typedef struct packed {
    logic            ide;
    logic [ID_W-1:0] id;
  } acc_reg_t;

  typedef struct packed {
    logic            ide;
    logic            rtr;
    logic [ID_W-1:0] id;
    logic [DB_W-1:0] db;
  } frame_t;
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_accept_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_mode,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  acc_reg_t                   wr_data,
  input  logic [SEL_W-1:0]           rd_sel,
  output acc_reg_t                   rd_data,
  output logic [ID_W-1:0]            mask0_o,
  output logic [ID_W-1:0]            mask1_o,
  output acc_reg_t [NUM_FILT-1:0]    filt_o
);
  acc_reg_t [NUM_REG-1:0] regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (cfg_mode && wr_en) regs_d[wr_sel] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign rd_data = cfg_mode ? regs_q[rd_sel] : '0;
  assign mask0_o = regs_q[0].id;
  assign mask1_o = regs_q[1].id;

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    assign filt_o[g] = regs_q[g+2];
  end
endmodule

// File: rtl/can_id_match.sv
module can_id_match
  import can_accept_pkg::*;
(
  input  logic [ID_W-1:0] mask_id,
  input  acc_reg_t        filt,
  input  frame_t          frm,
  output logic            hit
);
  logic [ID_W-1:0] diff;
  logic [DB_W-1:0] ddiff;

  always_comb begin
    diff  = (frm.id ^ filt.id) & mask_id;
    ddiff = (frm.db ^ filt.id[DB_W-1:0]) & mask_id[DB_W-1:0];
    if (filt.ide != frm.ide)
      hit = 1'b0;
    else if (frm.ide)
      hit = (diff == '0);
    else
      hit = (diff[ID_W-1 -: SID_W] == '0) && (frm.rtr || (ddiff == '0));
  end
endmodule

// File: rtl/can_buf_steer.sv
module can_buf_steer
  import can_accept_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_valid,
  input  logic [NUM_FILT-1:0] hit,
  input  logic [1:0]          mode0,
  input  logic [1:0]          mode1,
  input  logic                roll_en,
  input  logic [1:0]          full,
  output logic                load0_o,
  output logic                load1_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                ovf_o,
  output logic                irq_o
);
  logic [IDX_W-1:0] idx0, idx1, idx_d, idx_q;
  logic acc0, acc1, to1, ld0, ld1, ovf, irq_d;
  logic ld0_q, ld1_q, ovf_q, irq_q;

  always_comb begin
    idx0 = IDX_NONE;
    idx1 = IDX_NONE;
    for (int i = NUM_B0-1; i >= 0; i--)
      if (hit[i]) idx0 = IDX_W'(i);
    for (int i = NUM_FILT-1; i >= NUM_B0; i--)
      if (hit[i]) idx1 = IDX_W'(i);
    if (mode0 == MODE_ALL) idx0 = IDX_NONE;
    if (mode1 == MODE_ALL) idx1 = IDX_NONE;
    acc0 = (mode0 == MODE_ALL) || (|hit[NUM_B0-1:0]);
    acc1 = (mode1 == MODE_ALL) || (|hit[NUM_FILT-1:NUM_B0]);

    ld0   = 1'b0;
    ld1   = 1'b0;
    ovf   = 1'b0;
    to1   = 1'b0;
    idx_d = idx_q;
    if (frm_valid && (acc0 || acc1)) begin
      to1 = acc0 ? (roll_en && full[0]) : 1'b1;
      if (full[to1]) ovf = 1'b1;
      else begin
        ld0   = !to1;
        ld1   = to1;
        idx_d = acc0 ? idx0 : idx1;
      end
    end
    irq_d = ld0 || ld1 || (|full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld0_q <= 1'b0;
      ld1_q <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ld0_q <= ld0;
      ld1_q <= ld1;
      ovf_q <= ovf;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (ld0 || ld1) idx_q <= idx_d;
  end

  assign load0_o = ld0_q;
  assign load1_o = ld1_q;
  assign ovf_o   = ovf_q;
  assign irq_o   = irq_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/can_accept_steer.sv
module can_accept_steer
  import can_accept_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_wr_sel,
  input  logic             cfg_wr_ide,
  input  logic [28:0]      cfg_wr_bits,
  input  logic [2:0]       cfg_rd_sel,
  output logic             cfg_rd_ide,
  output logic [28:0]      cfg_rd_bits,
  input  logic [1:0]       buf0_mode,
  input  logic [1:0]       buf1_mode,
  input  logic             rollover_en,
  input  logic             frm_valid,
  input  logic             frm_ide,
  input  logic             frm_rtr,
  input  logic [28:0]      frm_id,
  input  logic [15:0]      frm_data,
  input  logic [1:0]       buf_full,
  output logic             load0,
  output logic             load1,
  output logic [2:0]       hit_idx,
  output logic             overflow,
  output logic             irq_req
);
  acc_reg_t                wr_data, rd_data;
  logic [ID_W-1:0]         mask0, mask1;
  acc_reg_t [NUM_FILT-1:0] filt;
  logic [NUM_FILT-1:0]     hit;
  frame_t                  frm;

  assign wr_data     = '{ide: cfg_wr_ide, id: cfg_wr_bits};
  assign cfg_rd_ide  = rd_data.ide;
  assign cfg_rd_bits = rd_data.id;
  assign frm         = '{ide: frm_ide, rtr: frm_rtr, id: frm_id, db: frm_data};

  can_filt_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_mode(cfg_mode),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (wr_data),
    .rd_sel  (cfg_rd_sel),
    .rd_data (rd_data),
    .mask0_o (mask0),
    .mask1_o (mask1),
    .filt_o  (filt)
  );

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_match
    can_id_match u_match (
      .mask_id(g < NUM_B0 ? mask0 : mask1),
      .filt   (filt[g]),
      .frm    (frm),
      .hit    (hit[g])
    );
  end

  can_buf_steer u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_valid(frm_valid),
    .hit      (hit),
    .mode0    (buf0_mode),
    .mode1    (buf1_mode),
    .roll_en  (rollover_en),
    .full     (buf_full),
    .load0_o  (load0),
    .load1_o  (load1),
    .idx_o    (hit_idx),
    .ovf_o    (overflow),
    .irq_o    (irq_req)
  );
endmodule

// File: rtl/can_accept_chk.sv
module can_accept_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_mode,
  input logic        cfg_rd_ide,
  input logic [28:0] cfg_rd_bits,
  input logic [1:0]  buf0_mode,
  input logic        rollover_en,
  input logic        frm_valid,
  input logic [1:0]  buf_full,
  input logic        load0,
  input logic        load1,
  input logic        overflow,
  input logic        irq_req
);
  // R11: at most one outcome per cycle
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load0, load1, overflow}));

  // R11: outcomes only follow a frame strobe
  a_r11_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (load0 || load1 || overflow) |-> $past(frm_valid));

  // R10: both buffers full means no load
  a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && buf_full == 2'b11) |=> (!load0 && !load1));

  // R9: accept-all buffer 0 with space always loads buffer 0
  a_r9_accept_all: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && buf0_mode == 2'b11 && !buf_full[0]) |=> load0);

  // R8: rollover of an accept-all buffer 0 into free buffer 1
  a_r8_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && buf0_mode == 2'b11 && rollover_en && buf_full == 2'b01) |=> load1);

  // R12: a load raises the interrupt request
  a_r12_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load0 || load1) |-> irq_req);

  // R2: readback is zero outside configuration mode
  a_r2_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> (cfg_rd_bits == '0 && !cfg_rd_ide));
endmodule

bind can_accept_steer can_accept_chk u_chk (.*);

// File: tb/can_accept_steer_bench.sv
module can_accept_steer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_mode = 1'b0, cfg_wr_en = 1'b0, cfg_wr_ide = 1'b0;
  logic [2:0]  cfg_wr_sel = '0, cfg_rd_sel = '0;
  logic [28:0] cfg_wr_bits = '0;
  logic        cfg_rd_ide;
  logic [28:0] cfg_rd_bits;
  logic [1:0]  buf0_mode = 2'b00, buf1_mode = 2'b00, buf_full = 2'b00;
  logic        rollover_en = 1'b0;
  logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [15:0] frm_data = '0;
  logic        load0, load1, overflow, irq_req;
  logic [2:0]  hit_idx;

  can_accept_steer u_can_accept_steer (.*);

  int n_chk = 0, n_bad = 0;
  logic [29:0] m_reg [8];
  logic [5:0]  exp_q [$];
  string       tag_q [$];
  logic        pend = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {load0, load1, overflow, hit_idx}
  function automatic logic [5:0] model(logic ide, logic rtr, logic [28:0] id, logic [15:0] db);
    logic [5:0] h;
    logic a0, a1, t1;
    logic [2:0] i0, i1, ix;
    for (int f = 0; f < 6; f++) begin
      logic [28:0] mk, fl;
      mk = m_reg[f < 2 ? 0 : 1][28:0];
      fl = m_reg[f+2][28:0];
      if (m_reg[f+2][29] != ide) h[f] = 1'b0;
      else if (ide) h[f] = ((id & mk) == (fl & mk));
      else h[f] = ((id[28:18] & mk[28:18]) == (fl[28:18] & mk[28:18])) &&
                  (rtr || ((db & mk[15:0]) == (fl[15:0] & mk[15:0])));
    end
    i0 = h[0] ? 3'd0 : 3'd7;
    i1 = h[2] ? 3'd2 : h[3] ? 3'd3 : h[4] ? 3'd4 : h[5] ? 3'd5 : 3'd7;
    a0 = (buf0_mode == 2'b11) || h[0] || h[1];
    a1 = (buf1_mode == 2'b11) || (|h[5:2]);
    if (buf0_mode == 2'b11) i0 = 3'd7;
    else if (!h[0] && h[1]) i0 = 3'd1;
    if (buf1_mode == 2'b11) i1 = 3'd7;
    if (!(a0 || a1)) return 6'b000_000;
    t1 = a0 ? (rollover_en && buf_full[0]) : 1'b1;
    ix = a0 ? i0 : i1;
    if (buf_full[t1]) return {3'b001, 3'd0};
    return {!t1, t1, 1'b0, ix};
  endfunction

  task automatic cfg_write(logic [2:0] sel, logic ide, logic [28:0] bits);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_ide = ide; cfg_wr_bits = bits;
    if (cfg_mode) m_reg[sel] = {ide, bits};
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic send(string tag, logic ide, logic rtr, logic [28:0] id, logic [15:0] db,
                      logic [5:0] hand);
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id; frm_data = db;
    check({tag, " model"}, 32'(model(ide, rtr, id, db)), 32'(hand));
    exp_q.push_back(hand);
    tag_q.push_back(tag);
    @(negedge clk);
    frm_valid = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) pend <= frm_valid;

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [5:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " outcome"}, {load0, load1, overflow}, e[5:3]);
      if (e[5] || e[4]) begin
        check({t, " hit_idx"}, 32'(hit_idx), 32'(e[2:0]));
        check({t, " R12 irq"}, 32'(irq_req), 32'd1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  localparam logic [28:0] ALL1 = '1;
  localparam logic [28:0] SIDM = {11'h7FF, 18'h0};

  initial begin
    for (int k = 0; k < 8; k++) m_reg[k] = '0;
    repeat (3) @(negedge clk);
    // reset state
    check("R11 reset load0", 32'(load0), 0);
    check("R11 reset load1", 32'(load1), 0);
    check("R10 reset overflow", 32'(overflow), 0);
    check("R12 reset irq", 32'(irq_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_mode = 1'b1;
    cfg_write(3'd0, 1'b0, ALL1);                        // mask 0: all bits
    cfg_write(3'd1, 1'b0, SIDM);                        // mask 1: standard id only
    cfg_write(3'd2, 1'b0, {11'h123, 18'h01234});        // filter 0
    cfg_write(3'd3, 1'b1, 29'h1ABCDEF);                 // filter 1
    cfg_write(3'd4, 1'b0, {11'h0F0, 18'h0});            // filter 2
    cfg_write(3'd5, 1'b0, {11'h123, 18'h0});            // filter 3
    cfg_write(3'd6, 1'b1, {11'h055, 18'h3FFFF});        // filter 4
    cfg_write(3'd7, 1'b0, {11'h3AA, 18'h0});            // filter 5
    cfg_rd_sel = 3'd3; #1;
    check("R2 readback filter1", {cfg_rd_ide, cfg_rd_bits}, {1'b1, 29'h1ABCDEF});
    cfg_rd_sel = 3'd1; #1;
    check("R2 readback mask1", {cfg_rd_ide, cfg_rd_bits}, {1'b0, SIDM});

    cfg_mode = 1'b0;
    @(negedge clk);
    cfg_rd_sel = 3'd0; #1;
    check("R2 readback zero outside config", {cfg_rd_ide, cfg_rd_bits}, 0);
    cfg_write(3'd0, 1'b0, 29'h0);                       // must be ignored (R1)

    // R7 R6 R5: std data matches filter 0 (data bytes too) and filter 3
    send("R7", 1'b0, 1'b0, {11'h123, 18'h0}, 16'h1234, {3'b100, 3'd0});
    // R6: data mismatch drops filter 0; mask 1 ignores data so filter 3 hits
    send("R6 data", 1'b0, 1'b0, {11'h123, 18'h0}, 16'h1235, {3'b010, 3'd3});
    // R6: remote frame skips data comparison
    send("R6 remote", 1'b0, 1'b1, {11'h123, 18'h0}, 16'h9999, {3'b100, 3'd0});
    // R4 R5: extended frame hits filter 1
    send("R4 ext", 1'b1, 1'b0, 29'h1ABCDEF, 16'h0, {3'b100, 3'd1});
    // R4: extended frame with std-filter bits is rejected (hit_idx holds)
    send("R4 ide", 1'b1, 1'b0, {11'h123, 18'h01234}, 16'h1234, 6'b000_000);
    // R5: filter 2 on buffer 1
    send("R5 buf1", 1'b0, 1'b0, {11'h0F0, 18'h0}, 16'hFFFF, {3'b010, 3'd2});
    // R3: masked-out bits ignored, masked-in bit checked
    send("R3 ignore", 1'b1, 1'b0, {11'h055, 18'h00000}, 16'h0, {3'b010, 3'd4});
    send("R3 compare", 1'b1, 1'b0, {11'h056, 18'h3FFFF}, 16'h0, 6'b000_000);
    check("R11 idle outputs", {load0, load1, overflow}, 0);

    // R1: re-enter config mode, mask 0 kept its value
    cfg_mode = 1'b1;
    cfg_rd_sel = 3'd0; #1;
    check("R1 write ignored outside config", {cfg_rd_ide, cfg_rd_bits}, {1'b0, ALL1});
    cfg_mode = 1'b0;

    // R10: buffer 0 full without rollover
    buf_full = 2'b01;
    send("R10 full0", 1'b0, 1'b0, {11'h123, 18'h0}, 16'h1234, {3'b001, 3'd0});
    check("R12 irq while full", 32'(irq_req), 1);
    // R8: rollover into buffer 1 keeps buffer 0 hit index
    rollover_en = 1'b1;
    send("R8 rollover", 1'b0, 1'b0, {11'h123, 18'h0}, 16'h1234, {3'b010, 3'd0});
    buf_full = 2'b11;
    send("R10 both full", 1'b0, 1'b0, {11'h123, 18'h0}, 16'h1234, {3'b001, 3'd0});
    buf_full = 2'b10;
    send("R10 full1", 1'b0, 1'b0, {11'h0F0, 18'h0}, 16'h0, {3'b001, 3'd0});
    buf_full = 2'b00;
    rollover_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 irq clears", 32'(irq_req), 0);

    // R9: accept-all modes
    buf0_mode = 2'b11;
    send("R9 buf0 all", 1'b1, 1'b0, 29'h0000777, 16'h0, {3'b100, 3'd7});
    buf0_mode = 2'b00; buf1_mode = 2'b11;
    send("R9 buf1 all", 1'b1, 1'b0, 29'h0000777, 16'h0, {3'b010, 3'd7});
    send("R9 buf0 wins", 1'b1, 1'b0, 29'h1ABCDEF, 16'h0, {3'b100, 3'd1});
    buf1_mode = 2'b00;

    repeat (3) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule